// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block carries a small processor's external memory accesses over two shared 8-bit ports. On the inside it takes one request at a time. A request has a 16-bit address, write data, a size (byte or 16-bit word) and a direction. The requester holds `req_valid` until a one-cycle `req_ready` pulse marks completion. For reads, `rsp_rdata` is valid during that pulse.

Towards the pins, the block derives an E clock from the internal clock. Each E cycle is four internal-clock quarters: two with E low, then two with E high. Each port places the address while E is low, so external devices can latch it at the rising edge of E. While E is high the port either drives write data or is released so the external device can drive read data, which is captured at the falling edge of E.

In wide mode both ports carry data. In narrow mode, data travels on port A only, port B keeps the low address byte for the whole access, and a word is split into two byte cycles with the high byte first. Every access can be lengthened by a configured number of extra E-high cycles. The control strobes (read/write, low-byte strobe, data bus enable) are each driven only when their own enable allows. In single-chip mode no bus pin is driven and no request is accepted.

Top module: `xbus_ctrl`

## Requirements
- R1: `eclk` runs continuously with a period of four clocks, low for two clocks and then high for two clocks, whenever no stretch is in progress.
- R2: During the E-low part of each bus cycle, both ports drive the cycle's address: port A carries bits 15:8 and port B carries bits 7:0. For a byte access the cycle address is `req_addr`. For a word access, the first cycle uses `req_addr` with bit 0 cleared and a second cycle, if there is one, uses it with bit 0 set.
- R3: Wide mode (`cfg_narrow`=0) uses one bus cycle. A word write drives `req_wdata[15:8]` on port A and `req_wdata[7:0]` on port B while E is high. A byte write puts `req_wdata[7:0]` on port A for an even address (bit 0 = 0) or on port B for an odd address. A read releases both ports while E is high and captures them at E fall. The word result is {A,B}; the byte result is the addressed lane, zero-extended.
- R4: Narrow mode (`cfg_narrow`=1) moves data only on port A, and port B keeps driving the address byte while E is high. A word becomes two consecutive bus cycles. The first carries data 15:8 and the second carries data 7:0, and a word read returns {first, second}. A byte access uses one cycle, with data in `req_wdata[7:0]` and `rsp_rdata[7:0]`.
- R5: With `cfg_stretch`=S, each bus cycle keeps E high for 2+4·S clocks. `req_ready` pulses only after the last cycle of the access ends.
- R6: `dbe_n` is active low and is driven (`dbe_oe`=1) in expanded mode unless `cfg_dbe_off`=1. With S=0 it is low for both E-high clocks of every bus cycle. With S>0 it is low only for the final clock of each bus cycle's last stretched E cycle.
- R7: `lstrb_n` is low during a bus cycle whose address has bit 0 = 1, or during a wide-mode word access, and high otherwise. `rw_n` is low during write cycles and high otherwise. Each pin is driven only in expanded mode when its enable (`cfg_lstrb_en`, `cfg_rw_en`) is 1.
- R8: A write drives no data while `cfg_rw_en`=0. A write cycle that involves the low byte (as defined for `lstrb_n` in R7) drives no data while `cfg_lstrb_en`=0. In both cases the access still completes with a `req_ready` pulse.
- R9: With `cfg_expanded`=0, no port or strobe output enable is asserted and requests are never accepted (`req_ready` stays 0).
- R10: `req_ready` lasts exactly one clock. It rises in the same clock in which `eclk` falls at the end of the final bus cycle.
- R11: After reset, `eclk`, `req_ready`, `pa_oe`, `pb_oe`, `rw_oe` and `lstrb_oe` are 0, and `dbe_oe`=1 with `dbe_n`=1 when expanded with `cfg_dbe_off`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, four per E cycle |
| rst | input | 1 | Synchronous active-high reset |
| cfg_expanded | input | 1 | 1 = expanded bus mode, 0 = single-chip |
| cfg_narrow | input | 1 | 1 = 8-bit data on port A, 0 = 16-bit data |
| cfg_stretch | input | STRETCH_W | Extra E-high cycles per bus cycle |
| cfg_rw_en | input | 1 | Enables the read/write strobe and writes |
| cfg_lstrb_en | input | 1 | Enables the low-byte strobe and low-byte writes |
| cfg_dbe_off | input | 1 | 1 = data bus enable pin not driven |
| req_valid | input | 1 | Request pending, held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 2*PORT_W | Access address |
| req_wdata | input | 2*PORT_W | Write data (byte in bits 7:0) |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 2*PORT_W | Read result |
| eclk | output | 1 | E clock |
| pa_out | output | PORT_W | Port A output value |
| pa_oe | output | 1 | Port A output enable |
| pa_in | input | PORT_W | Port A pin value |
| pb_out | output | PORT_W | Port B output value |
| pb_oe | output | 1 | Port B output enable |
| pb_in | input | PORT_W | Port B pin value |
| rw_n | output | 1 | Read/write strobe, low = write |
| rw_oe | output | 1 | Read/write pin drive enable |
| lstrb_n | output | 1 | Low-byte strobe, active low |
| lstrb_oe | output | 1 | Low-byte strobe drive enable |
| dbe_n | output | 1 | Data bus enable, active low |
| dbe_oe | output | 1 | Data bus enable drive enable |

## Verification
A single E fall can both end a narrow-mode word's first byte cycle and start its second. The read capture of the high byte and the switch of the port to the low-byte address happen in that same clock edge. The sweep provokes this by reading words in narrow mode at every stretch value, with an external memory model that answers each latched address with a different byte. A capture that is one clock late or early returns the wrong byte pair. Completion and E fall also share a clock, and the bench judges this by requiring `eclk` to have been high in the sample just before `req_ready` is first seen.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  // Quarter position inside one E cycle; the two upper codes are E-high.
  typedef enum logic [1:0] {
    Q_LOW_A  = 2'd0,
    Q_LOW_B  = 2'd1,
    Q_HIGH_A = 2'd2,
    Q_HIGH_B = 2'd3
  } qtr_e;

  function automatic logic qtr_is_high(input qtr_e q);
    return q[1];
  endfunction
endpackage

// File: rtl/xbus_eclk.sv
module xbus_eclk
  import xbus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  output qtr_e qtr,
  output logic q_end
);
  always_ff @(posedge clk) begin
    if (rst) qtr <= Q_LOW_A;
    else     qtr <= qtr_e'(qtr + 2'd1);
  end

  assign q_end = (qtr == Q_HIGH_B);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int PORT_W    = 8,
  parameter int STRETCH_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  q_end,
  input  logic                  cfg_expanded,
  input  logic                  cfg_narrow,
  input  logic [STRETCH_W-1:0]  cfg_stretch,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic                  req_word,
  input  logic [2*PORT_W-1:0]   req_addr,
  input  logic [2*PORT_W-1:0]   req_wdata,
  input  logic [PORT_W-1:0]     pa_in,
  input  logic [PORT_W-1:0]     pb_in,
  output logic                  busy,
  output logic                  beat,
  output logic [STRETCH_W-1:0]  scyc,
  output logic [2*PORT_W-1:0]   cur_addr,
  output logic                  lat_word,
  output logic                  lat_write,
  output logic                  lat_narrow,
  output logic [STRETCH_W-1:0]  lat_stretch,
  output logic [2*PORT_W-1:0]   lat_wdata,
  output logic                  req_ready,
  output logic [2*PORT_W-1:0]   rsp_rdata
);
  localparam int AW = 2 * PORT_W;

  logic [AW-1:0] lat_addr;
  logic          last_cyc;
  logic          two_beat;

  assign last_cyc = (scyc == lat_stretch);
  assign two_beat = lat_narrow & lat_word;
  assign cur_addr = lat_word ? {lat_addr[AW-1:1], beat} : lat_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      beat        <= 1'b0;
      scyc        <= '0;
      lat_addr    <= '0;
      lat_wdata   <= '0;
      lat_word    <= 1'b0;
      lat_write   <= 1'b0;
      lat_narrow  <= 1'b0;
      lat_stretch <= '0;
      req_ready   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      req_ready <= 1'b0;
      if (!busy) begin
        if (q_end && req_valid && cfg_expanded) begin
          busy        <= 1'b1;
          beat        <= 1'b0;
          scyc        <= '0;
          lat_addr    <= req_addr;
          lat_wdata   <= req_wdata;
          lat_word    <= req_word;
          lat_write   <= req_write;
          lat_narrow  <= cfg_narrow;
          lat_stretch <= cfg_stretch;
          rsp_rdata   <= '0;
        end
      end else if (q_end) begin
        if (!last_cyc) begin
          scyc <= scyc + 1'b1;
        end else begin
          if (!lat_write) begin
            if (lat_narrow) begin
              if (lat_word && !beat) rsp_rdata[AW-1:PORT_W] <= pa_in;
              else                   rsp_rdata[PORT_W-1:0]  <= pa_in;
            end else if (lat_word) begin
              rsp_rdata <= {pa_in, pb_in};
            end else begin
              rsp_rdata <= {{PORT_W{1'b0}}, (lat_addr[0] ? pb_in : pa_in)};
            end
          end
          if (two_beat && !beat) begin
            beat <= 1'b1;
            scyc <= '0;
          end else begin
            busy      <= 1'b0;
            req_ready <= 1'b1;
          end
        end
      end
    end
  end

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);

  assert_no_accept_single_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cfg_expanded) |=> !busy);

  assert_done_at_last_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(req_ready) |-> $past(busy) && !busy);
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int STRETCH_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  qtr_e                  qtr,
  input  logic                  cfg_expanded,
  input  logic                  cfg_rw_en,
  input  logic                  cfg_lstrb_en,
  input  logic                  cfg_dbe_off,
  input  logic                  busy,
  input  logic [STRETCH_W-1:0]  scyc,
  input  logic [2*PORT_W-1:0]   cur_addr,
  input  logic                  lat_word,
  input  logic                  lat_write,
  input  logic                  lat_narrow,
  input  logic [STRETCH_W-1:0]  lat_stretch,
  input  logic [2*PORT_W-1:0]   lat_wdata,
  output logic                  eclk,
  output logic [PORT_W-1:0]     pa_out,
  output logic                  pa_oe,
  output logic [PORT_W-1:0]     pb_out,
  output logic                  pb_oe,
  output logic                  rw_n,
  output logic                  rw_oe,
  output logic                  lstrb_n,
  output logic                  lstrb_oe,
  output logic                  dbe_n,
  output logic                  dbe_oe
);
  localparam int AW = 2 * PORT_W;

  logic e_high, addr_ph, touch_low, wr_ok, wdata_ph, hi_sel, dbe_act;

  assign e_high    = busy ? ((scyc != '0) || qtr_is_high(qtr)) : qtr_is_high(qtr);
  assign addr_ph   = busy && !e_high;
  assign touch_low = cur_addr[0] | (!lat_narrow & lat_word);
  assign wr_ok     = lat_write && cfg_rw_en && (!touch_low || cfg_lstrb_en);
  assign wdata_ph  = busy && e_high && wr_ok;
  assign hi_sel    = lat_word && !(lat_narrow && cur_addr[0]);

  always_comb begin
    if (lat_stretch == '0) dbe_act = busy && (scyc == '0) && qtr_is_high(qtr);
    else                   dbe_act = busy && (scyc == lat_stretch) && (qtr == Q_HIGH_B);
  end

  assign eclk     = e_high;
  assign pa_oe    = cfg_expanded && (addr_ph || wdata_ph);
  assign pa_out   = addr_ph ? cur_addr[AW-1:PORT_W]
                  : (hi_sel ? lat_wdata[AW-1:PORT_W] : lat_wdata[PORT_W-1:0]);
  assign pb_oe    = cfg_expanded && busy && (addr_ph || lat_narrow || wdata_ph);
  assign pb_out   = (addr_ph || lat_narrow) ? cur_addr[PORT_W-1:0] : lat_wdata[PORT_W-1:0];
  assign rw_oe    = cfg_expanded && cfg_rw_en;
  assign rw_n     = !(busy && lat_write);
  assign lstrb_oe = cfg_expanded && cfg_lstrb_en;
  assign lstrb_n  = !(busy && touch_low);
  assign dbe_oe   = cfg_expanded && !cfg_dbe_off;
  assign dbe_n    = !dbe_act;

  assert_dbe_in_ehigh_R6: assert property (@(posedge clk) disable iff (rst)
    (dbe_oe && !dbe_n) |-> eclk);

  assert_porta_data_write_R3: assert property (@(posedge clk) disable iff (rst)
    (pa_oe && eclk) |-> !rw_n);

  assert_ehigh_min_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(eclk) |-> ($past(eclk) && $past(eclk, 2)));

  assert_single_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !cfg_expanded |-> !(pa_oe || pb_oe || rw_oe || lstrb_oe || dbe_oe));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int STRETCH_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_expanded,
  input  logic                  cfg_narrow,
  input  logic [STRETCH_W-1:0]  cfg_stretch,
  input  logic                  cfg_rw_en,
  input  logic                  cfg_lstrb_en,
  input  logic                  cfg_dbe_off,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic                  req_word,
  input  logic [2*PORT_W-1:0]   req_addr,
  input  logic [2*PORT_W-1:0]   req_wdata,
  output logic                  req_ready,
  output logic [2*PORT_W-1:0]   rsp_rdata,
  output logic                  eclk,
  output logic [PORT_W-1:0]     pa_out,
  output logic                  pa_oe,
  input  logic [PORT_W-1:0]     pa_in,
  output logic [PORT_W-1:0]     pb_out,
  output logic                  pb_oe,
  input  logic [PORT_W-1:0]     pb_in,
  output logic                  rw_n,
  output logic                  rw_oe,
  output logic                  lstrb_n,
  output logic                  lstrb_oe,
  output logic                  dbe_n,
  output logic                  dbe_oe
);
  localparam int AW = 2 * PORT_W;

  qtr_e                 qtr;
  logic                 q_end;
  logic                 busy, beat;
  logic [STRETCH_W-1:0] scyc, lat_stretch;
  logic [AW-1:0]        cur_addr, lat_wdata;
  logic                 lat_word, lat_write, lat_narrow;

  xbus_eclk u_eclk (
    .clk   (clk),
    .rst   (rst),
    .qtr   (qtr),
    .q_end (q_end)
  );

  xbus_seq #(.PORT_W(PORT_W), .STRETCH_W(STRETCH_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .q_end        (q_end),
    .cfg_expanded (cfg_expanded),
    .cfg_narrow   (cfg_narrow),
    .cfg_stretch  (cfg_stretch),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_word     (req_word),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .pa_in        (pa_in),
    .pb_in        (pb_in),
    .busy         (busy),
    .beat         (beat),
    .scyc         (scyc),
    .cur_addr     (cur_addr),
    .lat_word     (lat_word),
    .lat_write    (lat_write),
    .lat_narrow   (lat_narrow),
    .lat_stretch  (lat_stretch),
    .lat_wdata    (lat_wdata),
    .req_ready    (req_ready),
    .rsp_rdata    (rsp_rdata)
  );

  xbus_pins #(.PORT_W(PORT_W), .STRETCH_W(STRETCH_W)) u_pins (
    .clk          (clk),
    .rst          (rst),
    .qtr          (qtr),
    .cfg_expanded (cfg_expanded),
    .cfg_rw_en    (cfg_rw_en),
    .cfg_lstrb_en (cfg_lstrb_en),
    .cfg_dbe_off  (cfg_dbe_off),
    .busy         (busy),
    .scyc         (scyc),
    .cur_addr     (cur_addr),
    .lat_word     (lat_word),
    .lat_write    (lat_write),
    .lat_narrow   (lat_narrow),
    .lat_stretch  (lat_stretch),
    .lat_wdata    (lat_wdata),
    .eclk         (eclk),
    .pa_out       (pa_out),
    .pa_oe        (pa_oe),
    .pb_out       (pb_out),
    .pb_oe        (pb_oe),
    .rw_n         (rw_n),
    .rw_oe        (rw_oe),
    .lstrb_n      (lstrb_n),
    .lstrb_oe     (lstrb_oe),
    .dbe_n        (dbe_n),
    .dbe_oe       (dbe_oe)
  );
endmodule

// File: tb/tb_xbus_ctrl.sv
module tb_xbus_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  logic cfg_expanded = 1'b1, cfg_narrow = 1'b0;
  logic [1:0] cfg_stretch = 2'd0;
  logic cfg_rw_en = 1'b0, cfg_lstrb_en = 1'b0, cfg_dbe_off = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic req_ready;
  logic [15:0] rsp_rdata;
  logic eclk, pa_oe, pb_oe, rw_n, rw_oe, lstrb_n, lstrb_oe, dbe_n, dbe_oe;
  logic [7:0] pa_out, pb_out, pa_in, pb_in;
  logic [15:0] lat = '0;

  int checks = 0, errors = 0;

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign pa_in = cfg_narrow ? mem(lat) : mem({lat[15:1], 1'b0});
  assign pb_in = mem({lat[15:1], 1'b1});

  xbus_ctrl dut (
    .clk(clk), .rst(rst), .cfg_expanded(cfg_expanded), .cfg_narrow(cfg_narrow),
    .cfg_stretch(cfg_stretch), .cfg_rw_en(cfg_rw_en), .cfg_lstrb_en(cfg_lstrb_en),
    .cfg_dbe_off(cfg_dbe_off), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .eclk(eclk),
    .pa_out(pa_out), .pa_oe(pa_oe), .pa_in(pa_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pb_in(pb_in), .rw_n(rw_n), .rw_oe(rw_oe), .lstrb_n(lstrb_n), .lstrb_oe(lstrb_oe),
    .dbe_n(dbe_n), .dbe_oe(dbe_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Per-transaction observations
  int         n_beats, n_ehigh, n_dbe;
  logic [15:0] b_addr [2];
  logic       b_lstrb [2], b_rw [2], a_drv [2], b_drv [2];
  logic [7:0] a_val [2], b_val [2];
  logic       got_ready, ready_after_e, ready_width_ok, saw_rw_oe;

  task automatic run_txn(input logic wr, input logic wd, input logic [15:0] a,
                         input logic [15:0] d);
    logic prev_e, addr_seen, fin;
    int guard;
    n_beats = 0; n_ehigh = 0; n_dbe = 0;
    for (int i = 0; i < 2; i++) begin
      b_addr[i] = '0; b_lstrb[i] = 1'b1; b_rw[i] = 1'b1;
      a_drv[i] = 1'b0; b_drv[i] = 1'b0; a_val[i] = '0; b_val[i] = '0;
    end
    got_ready = 0; ready_after_e = 0; ready_width_ok = 0; saw_rw_oe = 0;
    @(negedge clk);
    req_write = wr; req_word = wd; req_addr = a; req_wdata = d; req_valid = 1'b1;
    prev_e = eclk; addr_seen = 0; fin = 0; guard = 0;
    while (!fin && guard < 400) begin
      @(negedge clk);
      guard++;
      if (rw_oe) saw_rw_oe = 1;
      if (!eclk && pa_oe && pb_oe) begin lat = {pa_out, pb_out}; addr_seen = 1; end
      if (eclk && !prev_e && addr_seen && n_beats < 2) begin
        b_addr[n_beats] = lat; b_lstrb[n_beats] = lstrb_n; b_rw[n_beats] = rw_n;
        n_beats++; addr_seen = 0;
      end
      if (eclk && n_beats > 0) begin
        n_ehigh++;
        if (!dbe_n) n_dbe++;
        if (pa_oe) begin a_drv[n_beats-1] = 1; a_val[n_beats-1] = pa_out; end
        if (pb_oe) begin b_drv[n_beats-1] = 1; b_val[n_beats-1] = pb_out; end
      end
      if (req_ready) begin
        got_ready = 1; ready_after_e = prev_e && !eclk; fin = 1;
      end
      prev_e = eclk;
    end
    req_valid = 1'b0;
    @(negedge clk);
    ready_width_ok = !req_ready;
  endtask

  task automatic sweep_one(input logic nar, input int s, input logic wr,
                           input logic wd, input logic [15:0] a, input logic [15:0] d);
    int exp_beats, exp_hi;
    logic [15:0] ea [2];
    logic [15:0] exp_rd;
    string tag;
    cfg_narrow = nar; cfg_stretch = 2'(s);
    run_txn(wr, wd, a, d);
    tag = $sformatf("nar=%0d s=%0d wr=%0d wd=%0d a=%h", nar, s, wr, wd, a);
    exp_beats = (nar && wd) ? 2 : 1;
    ea[0] = wd ? {a[15:1], 1'b0} : a;
    ea[1] = {a[15:1], 1'b1};
    chk(got_ready, "R5", {"completion ", tag}, got_ready, 1);
    chk(ready_after_e && ready_width_ok, "R10", {"ready at E fall, one clock ", tag},
        {ready_after_e, ready_width_ok}, 2'b11);
    chk(n_beats == exp_beats, "R4", {"bus cycles ", tag}, n_beats, exp_beats);
    chk(n_ehigh == exp_beats * (2 + 4 * s), "R5", {"E-high clocks ", tag},
        n_ehigh, exp_beats * (2 + 4 * s));
    chk(n_dbe == exp_beats * ((s == 0) ? 2 : 1), "R6", {"DBE clocks ", tag},
        n_dbe, exp_beats * ((s == 0) ? 2 : 1));
    for (int b = 0; b < exp_beats; b++) begin
      logic exp_l;
      exp_l = !(ea[b][0] || (!nar && wd));
      chk(b_addr[b] == ea[b], "R2", {"cycle address ", tag}, b_addr[b], ea[b]);
      chk(b_lstrb[b] == exp_l && b_rw[b] == !wr, "R7", {"strobes ", tag},
          {b_lstrb[b], b_rw[b]}, {exp_l, !wr});
      if (nar) begin
        chk(b_drv[b] && b_val[b] == ea[b][7:0], "R4", {"port B holds address ", tag},
            b_val[b], ea[b][7:0]);
        if (wr) begin
          logic [7:0] ed;
          ed = (wd && b == 0) ? d[15:8] : d[7:0];
          chk(a_drv[b] && a_val[b] == ed, "R4", {"port A write byte ", tag}, a_val[b], ed);
        end else
          chk(!a_drv[b], "R4", {"port A released on read ", tag}, a_drv[b], 0);
      end else begin
        if (wr && wd) begin
          chk(a_drv[b] && b_drv[b] && a_val[b] == d[15:8] && b_val[b] == d[7:0], "R3",
              {"word write lanes ", tag}, {a_val[b], b_val[b]}, d);
        end else if (wr) begin
          if (a[0]) chk(b_drv[b] && b_val[b] == d[7:0], "R3", {"odd byte lane ", tag},
                        b_val[b], d[7:0]);
          else      chk(a_drv[b] && a_val[b] == d[7:0], "R3", {"even byte lane ", tag},
                        a_val[b], d[7:0]);
        end else
          chk(!a_drv[b] && !b_drv[b], "R3", {"ports released on read ", tag},
              {a_drv[b], b_drv[b]}, 0);
      end
    end
    if (!wr) begin
      exp_rd = wd ? {mem(ea[0]), mem(ea[1])} : {8'h00, mem(a)};
      chk(rsp_rdata == exp_rd, nar ? "R4" : "R3", {"read data ", tag}, rsp_rdata, exp_rd);
    end
  endtask

  logic wd_done = 0;
  initial begin
    #1_000_000;
    if (!wd_done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!eclk && !req_ready && !pa_oe && !pb_oe && !rw_oe && !lstrb_oe, "R11",
        "outputs after reset", {eclk, req_ready, pa_oe, pb_oe, rw_oe, lstrb_oe}, 0);
    chk(dbe_oe && dbe_n, "R11", "DBE default", {dbe_oe, dbe_n}, 2'b11);

    // R1 free-running E: measure one high run and one low run
    begin
      int hi, lo, g;
      g = 0;
      while (eclk && g < 20) begin @(negedge clk); g++; end
      while (!eclk && g < 20) begin @(negedge clk); g++; end
      hi = 0; lo = 0;
      while (eclk && g < 40) begin hi++; @(negedge clk); g++; end
      while (!eclk && g < 40) begin lo++; @(negedge clk); g++; end
      chk(hi == 2 && lo == 2, "R1", "E high/low clocks", {hi[7:0], lo[7:0]}, 16'h0202);
    end

    // Main sweep: both widths, every stretch, byte even/odd and word, read/write
    cfg_rw_en = 1'b1; cfg_lstrb_en = 1'b1;
    for (int nar = 0; nar < 2; nar++)
      for (int s = 0; s < 4; s++)
        for (int k = 0; k < 3; k++)
          for (int wr = 0; wr < 2; wr++) begin
            logic [15:0] a;
            a = 16'h3A40 + 16'(nar * 16'h1234 + s * 16'h0110 + k * 2) + ((k == 1) ? 16'd1 : 16'd0);
            sweep_one(nar[0], s, wr[0], (k == 2), a, 16'hC3A5 ^ 16'(s * 16'h1111 + k));
          end

    // R8: writes blocked by strobe enables
    cfg_narrow = 1'b0; cfg_stretch = 2'd0;
    cfg_rw_en = 1'b0;
    run_txn(1'b1, 1'b1, 16'h1200, 16'hBEEF);
    chk(got_ready && !a_drv[0] && !b_drv[0] && !saw_rw_oe, "R8",
        "write with rw disabled", {got_ready, a_drv[0], b_drv[0], saw_rw_oe}, 4'b1000);
    cfg_rw_en = 1'b1; cfg_lstrb_en = 1'b0;
    run_txn(1'b1, 1'b0, 16'h1201, 16'h0077);
    chk(got_ready && !a_drv[0] && !b_drv[0] && !lstrb_oe, "R8",
        "odd byte write with lstrb disabled", {got_ready, a_drv[0], b_drv[0]}, 3'b100);
    run_txn(1'b1, 1'b0, 16'h1202, 16'h0066);
    chk(a_drv[0] && a_val[0] == 8'h66, "R8", "even byte write with lstrb disabled",
        a_val[0], 8'h66);
    cfg_lstrb_en = 1'b1;

    // R6: DBE disabled
    cfg_dbe_off = 1'b1;
    @(negedge clk);
    chk(!dbe_oe, "R6", "DBE released when disabled", dbe_oe, 0);
    cfg_dbe_off = 1'b0;

    // R9: single-chip mode ignores requests and drives nothing
    cfg_expanded = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_word = 1'b1; req_addr = 16'h4444;
    begin
      logic bad;
      bad = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (req_ready || pa_oe || pb_oe || rw_oe || lstrb_oe || dbe_oe) bad = 1;
      end
      chk(!bad, "R9", "single-chip quiet", bad, 0);
    end
    req_valid = 1'b0;
    cfg_expanded = 1'b1;
    repeat (8) @(negedge clk);

    wd_done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule